// File: doc/BRIEF.md
# Registered 16-bit ALU with status flags

This block is a single-stage arithmetic logic unit placed between input registers and output registers. On every clock edge it captures two 16-bit operands, a 4-bit operation code and a carry input. On the following edge it registers the 16-bit result together with four status flags: zero, negative, carry and overflow. Every arithmetic operation runs in a 17-bit datapath. Both operands are zero-extended, so the carry is simply bit 16 of the sum and the sign is bit 15.

Subtraction is done by adding the bitwise inverse of B. A carry input of 1 therefore means no borrow. Decrement adds the all-ones constant, so no separate subtractor is needed. Surrounding logic drives a new operation on every cycle and reads the registered result and flags two edges later. The pipeline accepts back-to-back operations with no stalls.

Top module: `reg_alu16`

## Requirements
- R1: A synchronous active-high reset clears the operand, result and flag registers. After a reset edge, `result` is 0 and all four flags are 0, including the zero flag.
- R2: Inputs present before clock edge k appear on `result` and the flags after edge k+1. A new operation may be presented on every cycle.
- R3: Code 4'h0 copies A to the result and code 4'hB copies B to the result. Both clear carry and overflow.
- R4: Code 4'h1 gives {carry, result} = A + B, and code 4'h2 gives {carry, result} = A + B + carry_in. Both sums are taken over 17 bits.
- R5: Code 4'h3 gives {carry, result} = A + ~B + 1, and code 4'h4 gives {carry, result} = A + ~B + carry_in. In both, a carry of 1 means no borrow.
- R6: Code 4'h5 gives {carry, result} = A + 1, and code 4'h6 gives {carry, result} = A + 16'hFFFF. Decrementing 0 therefore gives carry 0, and decrementing any other value gives carry 1.
- R7: For codes 4'h1 to 4'h6, overflow is set exactly when A[15] equals S[15] and result[15] differs from A[15]. S is B for adds, ~B for subtracts, 0 for increment and 16'hFFFF for decrement.
- R8: Code 4'h7 computes AND, 4'h8 computes OR, 4'h9 computes XOR and 4'hA computes NOT A. All four clear carry and overflow.
- R9: Codes 4'hC to 4'hF give result 0 with zero flag 1 and carry, overflow and negative flags 0.
- R10: Outside reset, the zero flag equals (result == 0) and the negative flag equals result[15] for every operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 16 | Operand A |
| b_in | input | 16 | Operand B |
| op_in | input | 4 | Operation code |
| carry_in | input | 1 | Carry input for the carry-using operations |
| result | output | 16 | Registered result |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag (result bit 15) |
| flag_c | output | 1 | Carry flag (bit 16 of the wide sum) |
| flag_v | output | 1 | Signed overflow flag |

## Verification
Several properties are checked on every cycle once two clean edges have passed since reset. The checker compares the pass of A and the carry-using add and subtract sums against the inputs from two cycles earlier. It also checks that logic operations and unused codes never raise carry or overflow, that the zero flag agrees with the result, and what reset leaves behind. Some behaviour is shown only by the bench's scenarios, which use a separate signed and unsigned integer model. These cover the overflow boundaries at 16'h7FFF and 16'h8000, the carry of a decrement at 0, the two carry-in values of SBC, and back-to-back issue with the stated two-edge timing.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    typedef enum logic [3:0] {
        OP_MOVA = 4'h0,
        OP_ADD  = 4'h1,
        OP_ADC  = 4'h2,
        OP_SUB  = 4'h3,
        OP_SBC  = 4'h4,
        OP_INC  = 4'h5,
        OP_DEC  = 4'h6,
        OP_AND  = 4'h7,
        OP_OR   = 4'h8,
        OP_XOR  = 4'h9,
        OP_NOTA = 4'hA,
        OP_MOVB = 4'hB
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic c;
        logic v;
    } alu_flags_t;

endpackage

// File: rtl/alu16_core.sv
module alu16_core
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [3:0]   op,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout,
    output logic         ovf
);
    localparam int XW = W + 1;

    logic [W-1:0]  second;
    logic          cin_eff;
    logic          arith;
    logic [W-1:0]  logic_res;
    logic [XW-1:0] wide;

    // Select the second addend and carry for arithmetic codes, or the
    // bitwise / move result for all others.
    always_comb begin
        second    = '0;
        cin_eff   = 1'b0;
        arith     = 1'b0;
        logic_res = '0;
        case (alu_op_e'(op))
            OP_ADD:  begin arith = 1'b1; second = b;         cin_eff = 1'b0; end
            OP_ADC:  begin arith = 1'b1; second = b;         cin_eff = cin;  end
            OP_SUB:  begin arith = 1'b1; second = ~b;        cin_eff = 1'b1; end
            OP_SBC:  begin arith = 1'b1; second = ~b;        cin_eff = cin;  end
            OP_INC:  begin arith = 1'b1; second = '0;        cin_eff = 1'b1; end
            OP_DEC:  begin arith = 1'b1; second = {W{1'b1}}; cin_eff = 1'b0; end
            OP_MOVA: logic_res = a;
            OP_MOVB: logic_res = b;
            OP_AND:  logic_res = a & b;
            OP_OR:   logic_res = a | b;
            OP_XOR:  logic_res = a ^ b;
            OP_NOTA: logic_res = ~a;
            default: logic_res = '0;
        endcase
    end

    // One adder over the zero-extended width; carry falls out of the top bit.
    assign wide = {1'b0, a} + {1'b0, second} + {{W{1'b0}}, cin_eff};

    assign res  = arith ? wide[W-1:0] : logic_res;
    assign cout = arith & wide[W];
    assign ovf  = arith & (a[W-1] == second[W-1]) & (wide[W-1] != a[W-1]);

endmodule

// File: rtl/alu16_status.sv
module alu16_status #(
    parameter int W = 16
) (
    input  logic [W-1:0] res,
    output logic         zero,
    output logic         neg
);
    assign zero = (res == '0);
    assign neg  = res[W-1];
endmodule

// File: rtl/reg_alu16.sv
module reg_alu16
    import alu16_pkg::*;
#(
    parameter int W  = 16,
    parameter int OPW = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [W-1:0]   a_in,
    input  logic [W-1:0]   b_in,
    input  logic [OPW-1:0] op_in,
    input  logic           carry_in,
    output logic [W-1:0]   result,
    output logic           flag_z,
    output logic           flag_n,
    output logic           flag_c,
    output logic           flag_v
);
    logic [W-1:0]   a_q;
    logic [W-1:0]   b_q;
    logic [OPW-1:0] op_q;
    logic           cin_q;

    logic [W-1:0]   core_res;
    logic           core_c;
    logic           core_v;
    logic           st_z;
    logic           st_n;

    alu_flags_t     flags_q;
    logic [W-1:0]   res_q;

    // Operand stage
    always_ff @(posedge clk) begin
        if (rst) begin
            a_q   <= '0;
            b_q   <= '0;
            op_q  <= '0;
            cin_q <= 1'b0;
        end else begin
            a_q   <= a_in;
            b_q   <= b_in;
            op_q  <= op_in;
            cin_q <= carry_in;
        end
    end

    alu16_core #(.W(W)) u_core (
        .a    (a_q),
        .b    (b_q),
        .op   (op_q),
        .cin  (cin_q),
        .res  (core_res),
        .cout (core_c),
        .ovf  (core_v)
    );

    alu16_status #(.W(W)) u_status (
        .res  (core_res),
        .zero (st_z),
        .neg  (st_n)
    );

    // Result stage
    always_ff @(posedge clk) begin
        if (rst) begin
            res_q   <= '0;
            flags_q <= '0;
        end else begin
            res_q   <= core_res;
            flags_q <= '{z: st_z, n: st_n, c: core_c, v: core_v};
        end
    end

    assign result = res_q;
    assign flag_z = flags_q.z;
    assign flag_n = flags_q.n;
    assign flag_c = flags_q.c;
    assign flag_v = flags_q.v;

endmodule

// File: rtl/alu16_chk.sv
module alu16_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic [3:0]   op_in,
    input logic         carry_in,
    input logic [W-1:0] result,
    input logic         flag_z,
    input logic         flag_n,
    input logic         flag_c,
    input logic         flag_v
);
    // Edges since reset, saturating; results are meaningful from 2 onward.
    logic [1:0] seen;
    always_ff @(posedge clk) begin
        if (rst)              seen <= 2'd0;
        else if (seen != 2'd3) seen <= seen + 2'd1;
    end

    // R1: reset leaves everything cleared
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (result == '0 && !flag_z && !flag_n && !flag_c && !flag_v));

    // R3 with R2 timing: pass of A
    a_r3_pass_a: assert property (@(posedge clk) disable iff (rst)
        (seen >= 2'd2 && $past(op_in, 2) == 4'h0) |->
            (result == $past(a_in, 2) && !flag_c && !flag_v));

    // R4: add with carry over 17 bits
    a_r4_adc_sum: assert property (@(posedge clk) disable iff (rst)
        (seen >= 2'd2 && $past(op_in, 2) == 4'h2) |->
            ({flag_c, result} == ({1'b0, $past(a_in, 2)} + {1'b0, $past(b_in, 2)}
                                   + {{W{1'b0}}, $past(carry_in, 2)})));

    // R5: subtract with carry over 17 bits
    a_r5_sbc_sum: assert property (@(posedge clk) disable iff (rst)
        (seen >= 2'd2 && $past(op_in, 2) == 4'h4) |->
            ({flag_c, result} == ({1'b0, $past(a_in, 2)} + {1'b0, ~$past(b_in, 2)}
                                   + {{W{1'b0}}, $past(carry_in, 2)})));

    // R8: logic codes never raise carry or overflow
    a_r8_logic_no_cv: assert property (@(posedge clk) disable iff (rst)
        (seen >= 2'd2 && $past(op_in, 2) >= 4'h7 && $past(op_in, 2) <= 4'hA) |->
            (!flag_c && !flag_v));

    // R9: unused codes give a zero result
    a_r9_unused_zero: assert property (@(posedge clk) disable iff (rst)
        (seen >= 2'd2 && $past(op_in, 2) >= 4'hC) |->
            (result == '0 && flag_z && !flag_n && !flag_c && !flag_v));

    // R10: zero and negative agree with the result
    a_r10_zn_match: assert property (@(posedge clk) disable iff (rst)
        (seen >= 2'd1) |-> (flag_z == (result == '0) && flag_n == result[W-1]));

endmodule

bind reg_alu16 alu16_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .a_in     (a_in),
    .b_in     (b_in),
    .op_in    (op_in),
    .carry_in (carry_in),
    .result   (result),
    .flag_z   (flag_z),
    .flag_n   (flag_n),
    .flag_c   (flag_c),
    .flag_v   (flag_v)
);

// File: tb/tb_reg_alu16.sv
module tb_reg_alu16;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] a_in = '0;
    logic [15:0] b_in = '0;
    logic [3:0]  op_in = '0;
    logic        carry_in = 1'b0;
    logic [15:0] result;
    logic        flag_z, flag_n, flag_c, flag_v;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int          due;
        string       tag;
        logic [15:0] r;
        logic        z, n, c, v;
    } exp_t;

    exp_t sb[$];

    reg_alu16 dut (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .op_in(op_in),
        .carry_in(carry_in), .result(result), .flag_z(flag_z),
        .flag_n(flag_n), .flag_c(flag_c), .flag_v(flag_v)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int sgn(int x);
        return (x >= 32768) ? x - 65536 : x;
    endfunction

    // Independent integer model of the requirements
    function automatic exp_t model(logic [3:0] op, logic [15:0] a, logic [15:0] b, logic ci);
        exp_t e;
        int ua = int'(a);
        int ub = int'(b);
        int add2 = 0;
        int cc = 0;
        bit ar = 1'b1;
        int s, sx;
        e.c = 1'b0; e.v = 1'b0; e.r = '0;
        case (op)
            4'h1: begin add2 = ub;         cc = 0;      e.tag = "R4 ADD"; end
            4'h2: begin add2 = ub;         cc = int'(ci); e.tag = "R4 ADC"; end
            4'h3: begin add2 = 65535 - ub; cc = 1;      e.tag = "R5 SUB"; end
            4'h4: begin add2 = 65535 - ub; cc = int'(ci); e.tag = "R5 SBC"; end
            4'h5: begin add2 = 0;          cc = 1;      e.tag = "R6 INC"; end
            4'h6: begin add2 = 65535;      cc = 0;      e.tag = "R6 DEC"; end
            default: ar = 1'b0;
        endcase
        if (ar) begin
            s   = ua + add2 + cc;
            sx  = sgn(ua) + sgn(add2) + cc;
            e.r = 16'(s % 65536);
            e.c = (s > 65535);
            e.v = (sx > 32767) || (sx < -32768);   // R7
        end else begin
            case (op)
                4'h0: begin e.r = a;     e.tag = "R3 MOVA"; end
                4'hB: begin e.r = b;     e.tag = "R3 MOVB"; end
                4'h7: begin e.r = a & b; e.tag = "R8 AND";  end
                4'h8: begin e.r = a | b; e.tag = "R8 OR";   end
                4'h9: begin e.r = a ^ b; e.tag = "R8 XOR";  end
                4'hA: begin e.r = ~a;    e.tag = "R8 NOTA"; end
                default: begin e.r = '0; e.tag = "R9 UNUSED"; end
            endcase
        end
        e.z = (e.r == 16'h0000);   // R10
        e.n = e.r[15];
        return e;
    endfunction

    // Driver: one operation per cycle, expected item due two edges later (R2)
    task automatic drive(input logic [3:0] op, input logic [15:0] a,
                         input logic [15:0] b, input logic ci);
        exp_t e;
        @(negedge clk);
        op_in = op; a_in = a; b_in = b; carry_in = ci;
        e = model(op, a, b, ci);
        e.due = cyc + 2;
        sb.push_back(e);
    endtask

    // Monitor: compares on the falling edge when an item falls due
    always @(negedge clk) begin
        if (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if ({result, flag_z, flag_n, flag_c, flag_v} !== {e.r, e.z, e.n, e.c, e.v}) begin
                failures++;
                $display("FAIL %s (R2 timing, R7, R10 flags): got r=%h znvc=%b%b%b%b exp r=%h znvc=%b%b%b%b",
                         e.tag, result, flag_z, flag_n, flag_v, flag_c,
                         e.r, e.z, e.n, e.v, e.c);
            end
        end
    end

    task automatic check_cleared(input string what);
        checks++;
        if ({result, flag_z, flag_n, flag_c, flag_v} !== 20'h0) begin
            failures++;
            $display("FAIL R1 %s: got r=%h zncv=%b%b%b%b exp r=0000 zncv=0000",
                     what, result, flag_z, flag_n, flag_c, flag_v);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_cleared("after power-up reset");
        rst = 1'b0;

        drive(4'h0, 16'h1234, 16'hAAAA, 1'b1);  // R3 pass A
        drive(4'h1, 16'h7FFF, 16'h0001, 1'b1);  // R4, R7 positive overflow
        drive(4'h1, 16'hFFFF, 16'h0001, 1'b0);  // R4 carry, zero
        drive(4'h2, 16'h0001, 16'h0002, 1'b1);  // R4 ADC carry in
        drive(4'h2, 16'hFFFF, 16'h0000, 1'b1);  // R4 ADC wrap
        drive(4'h3, 16'h0005, 16'h0005, 1'b0);  // R5 equal, no borrow
        drive(4'h3, 16'h0003, 16'h0005, 1'b1);  // R5 borrow, negative
        drive(4'h3, 16'h8000, 16'h0001, 1'b0);  // R5, R7 negative overflow
        drive(4'h4, 16'h000A, 16'h0003, 1'b0);  // R5 SBC with borrow in
        drive(4'h4, 16'h000A, 16'h0003, 1'b1);  // R5 SBC no borrow in
        drive(4'h4, 16'h0000, 16'h0000, 1'b0);  // R5 SBC to all ones
        drive(4'h5, 16'h7FFF, 16'h0000, 1'b0);  // R6, R7 increment overflow
        drive(4'h5, 16'hFFFF, 16'h0000, 1'b0);  // R6 increment wrap
        drive(4'h6, 16'h0000, 16'h0000, 1'b1);  // R6 decrement of zero: carry 0
        drive(4'h6, 16'h8000, 16'h0000, 1'b0);  // R6, R7 decrement overflow
        drive(4'h6, 16'h0001, 16'h0000, 1'b0);  // R6 decrement to zero
        drive(4'h7, 16'hF0F0, 16'h3C3C, 1'b1);  // R8
        drive(4'h8, 16'hF0F0, 16'h0F0F, 1'b1);  // R8
        drive(4'h9, 16'hFFFF, 16'hFFFF, 1'b1);  // R8 zero result
        drive(4'hA, 16'hFFFF, 16'h1234, 1'b1);  // R8 NOT
        drive(4'hB, 16'h0000, 16'h8001, 1'b1);  // R3 pass B
        drive(4'hC, 16'hFFFF, 16'hFFFF, 1'b1);  // R9
        drive(4'hF, 16'h8000, 16'h8000, 1'b1);  // R9
        drive(4'h0, 16'h8765, 16'h0000, 1'b0);  // leaves nonzero state
        repeat (4) @(negedge clk);

        // R1: reset in the middle of operation clears held values
        rst = 1'b1;
        @(negedge clk);
        check_cleared("after mid-run reset");
        rst = 1'b0;
        drive(4'h1, 16'h0001, 16'h0001, 1'b0);  // R2 first op after reset
        repeat (4) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (2000) @(posedge clk);
                failures++;
                $display("FAIL watchdog: got hang exp completion");
            end
        join_any
        checks++;
        if (sb.size() != 0) begin
            failures++;
            $display("FAIL R2 pending items: got %0d exp 0", sb.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule